// File: doc/BRIEF.md
# Synchronous Burst Memory Access Controller

This block sits on the host side of an external pseudo-static RAM and runs synchronous burst reads and writes against it. The host hands over one request at a time: a start address, a direction, and a choice between a fixed-length burst or a continuous burst. The controller then drives the memory control pins in a strict order. First it asserts chip enable together with a single address-valid cycle that also carries the direction. Next it lets a fixed number of latency clocks pass. Finally it streams data words between the host and the memory.

The burst length code and the initial latency come from a configuration input that mirrors the memory's own burst configuration. Both are captured when a request is accepted. On the host side, data moves through valid/ready handshakes. When the host is not ready during the data phase, the controller holds the memory clock enable low, so the memory pauses with it. A continuous burst runs to the end of its 128-word row, or it stops early when the host raises abort. At the end of every burst the controller gives a one-cycle done pulse together with the number of words moved.

Top module: `sbm_burst_ctrl`

## Requirements
- R1: After reset, and whenever no burst is active, the outputs are as follows. mem_ce_n, mem_adv_n, mem_we_n and mem_oe_n are high. mem_clk_en, done and done_count are 0. req_ready is 1.
- R2: A request is accepted at the clock edge where req_valid and req_ready are both high. In the next cycle mem_ce_n and mem_adv_n are both low, mem_addr equals the request address, and mem_we_n equals the inverse of req_write (1 = read, 0 = write). mem_adv_n is low for exactly one cycle per burst.
- R3: Count the address cycle as index 0. With a captured latency L (0 to 15), the first data cycle is cycle index L+1. mem_clk_en is 1 in the address cycle and in every latency cycle.
- R4: For a fixed burst, length code 0, 1, 2 and 3 selects 4, 8, 16 and 32 words. The address rises by one per word and crosses a 128-word row boundary linearly, with no wrap.
- R5: A continuous burst ends after the word whose low 7 address bits equal 127, so it moves 128 minus the start address's low 7 bits.
- R6: In the cycle after the last word, mem_ce_n is high. In that same cycle done is 1 for one cycle only, and done_count equals the number of words moved.
- R7: When abort is high at a clock edge during a continuous burst, mem_ce_n is high in the next cycle. The done count then includes any word that moved at that edge.
- R8: During a fixed burst, abort has no effect, and the full length is moved.
- R9: In the read data phase, mem_oe_n is low, rd_valid is 1, and rd_data equals mem_dq_in. A word moves only when rd_ready is 1, and mem_clk_en equals rd_ready. mem_oe_n is low in no other cycle.
- R10: In the write data phase, wr_ready is 1, mem_dq_oe is 1, and mem_dq_out equals wr_data. A word moves only when wr_valid is 1, and mem_clk_en equals wr_valid. While no word moves, mem_addr holds.
- R11: The length code and the latency are sampled only when a request is accepted. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_code | input | 2 | Fixed burst length code (4 << code words) |
| cfg_latency | input | LAT_W | Initial latency in clocks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Burst start address |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_cont | input | 1 | 1 = continuous to row end, 0 = fixed length |
| abort | input | 1 | Ends a continuous burst at the next clock |
| wr_valid | input | 1 | Host write word available |
| wr_ready | output | 1 | Write data phase, word taken when wr_valid |
| wr_data | input | DATA_W | Host write word |
| rd_valid | output | 1 | Read data phase, word on rd_data |
| rd_ready | input | 1 | Host accepts read word |
| rd_data | output | DATA_W | Read word from memory |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_count | output | ROW_BITS+1 | Words moved in the finished burst |
| mem_clk_en | output | 1 | Memory clock enable |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv_n | output | 1 | Memory address valid, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Write data to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Read data from memory |

## Verification
A request accepted at a clock edge shows its address cycle one cycle later. The first data cycle then follows L+1 cycles after that address cycle, and the done pulse comes exactly one cycle after the last handshake, or one cycle after an abort edge. The bench numbers the cycles from the address cycle and checks each result in its own cycle. It drives the handshake and abort inputs at the falling edge and samples the outputs shortly after, so the combinational handshake outputs are read before the rising edge that acts on them. The ready patterns include stall cycles, and in each stall the bench checks that the address is frozen and the clock enable is low.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_LAT  = 2'd2,
        ST_DATA = 2'd3
    } sbm_state_e;

    localparam int LEN_CODE_W = 2;
    localparam int MIN_BURST  = 4;

endpackage

// File: rtl/sbm_len_decode.sv
module sbm_len_decode
    import sbm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    output logic [CNT_W-1:0]      words
);
    localparam int NCODES = 1 << LEN_CODE_W;

    logic [CNT_W-1:0] table_w [NCODES];

    for (genvar i = 0; i < NCODES; i++) begin : g_len
        assign table_w[i] = CNT_W'(MIN_BURST << i);
    end

    assign words = table_w[len_code];

endmodule

// File: rtl/sbm_addr_step.sv
module sbm_addr_step #(
    parameter int ADDR_W   = 22,
    parameter int ROW_BITS = 7
) (
    input  logic [ADDR_W-1:0] addr_cur,
    output logic [ADDR_W-1:0] addr_next,
    output logic              row_last
);
    assign addr_next = addr_cur + ADDR_W'(1);

    if (ROW_BITS < ADDR_W) begin : g_row_part
        assign row_last = &addr_cur[ROW_BITS-1:0];
    end else begin : g_row_full
        assign row_last = &addr_cur;
    end

endmodule

// File: rtl/sbm_lat_timer.sv
module sbm_lat_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    input  logic             dec,
    output logic [LAT_W-1:0] remaining
);
    logic [LAT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - LAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign remaining = cnt_q;

endmodule

// File: rtl/sbm_burst_ctrl.sv
module sbm_burst_ctrl
    import sbm_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int LAT_W    = 4,
    parameter int ROW_BITS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cfg_len_code,
    input  logic [LAT_W-1:0]      cfg_latency,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic                  req_cont,
    input  logic                  abort,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  done,
    output logic [ROW_BITS:0]     done_count,
    output logic                  mem_clk_en,
    output logic                  mem_ce_n,
    output logic                  mem_adv_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);
    localparam int CNT_W = ROW_BITS + 1;

    typedef struct packed {
        sbm_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic             wr;
        logic             cont;
        logic [CNT_W-1:0] target;
        logic [CNT_W-1:0] moved;
        logic             done;
    } regs_t;

    regs_t d, q;

    logic [CNT_W-1:0]  cfg_words;
    logic [ADDR_W-1:0] addr_next;
    logic              row_last;
    logic              lat_load;
    logic              lat_dec;
    logic [LAT_W-1:0]  lat_left;
    logic              xfer;
    logic              last_word;
    logic [CNT_W-1:0]  moved_inc;

    sbm_len_decode #(.CNT_W(CNT_W)) u_len (
        .len_code (cfg_len_code),
        .words    (cfg_words)
    );

    sbm_addr_step #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)) u_step (
        .addr_cur  (q.addr),
        .addr_next (addr_next),
        .row_last  (row_last)
    );

    sbm_lat_timer #(.LAT_W(LAT_W)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (lat_load),
        .load_val  (cfg_latency),
        .dec       (lat_dec),
        .remaining (lat_left)
    );

    // Handshake of the current data cycle: the memory clock advances with it.
    assign xfer      = (q.st == ST_DATA) && (q.wr ? wr_valid : rd_ready);
    assign moved_inc = q.moved + CNT_W'(1);
    assign last_word = q.cont ? row_last : (moved_inc == q.target);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        lat_load = 1'b0;
        lat_dec  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_ADDR;
                    d.addr   = req_addr;
                    d.wr     = req_write;
                    d.cont   = req_cont;
                    d.target = cfg_words;
                    d.moved  = '0;
                    lat_load = 1'b1;
                end
            end
            ST_ADDR: begin
                d.st = (lat_left == '0) ? ST_DATA : ST_LAT;
            end
            ST_LAT: begin
                lat_dec = 1'b1;
                if (lat_left <= LAT_W'(1)) d.st = ST_DATA;
            end
            ST_DATA: begin
                if (xfer) begin
                    d.moved = moved_inc;
                    d.addr  = addr_next;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        // Completion: last word moved, or early stop of a continuous burst.
        if ((xfer && last_word) || (q.st != ST_IDLE && q.cont && abort)) begin
            d.st   = ST_IDLE;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, addr: '0, wr: 1'b0, cont: 1'b0,
                   target: '0, moved: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_ce_n   = (q.st == ST_IDLE);
    assign mem_adv_n  = (q.st != ST_ADDR);
    assign mem_we_n   = (q.st == ST_IDLE) ? 1'b1 : !q.wr;
    assign mem_oe_n   = !((q.st == ST_DATA) && !q.wr);
    assign mem_clk_en = (q.st == ST_ADDR) || (q.st == ST_LAT) || xfer;
    assign mem_addr   = q.addr;
    assign mem_dq_out = wr_data;
    assign mem_dq_oe  = (q.st == ST_DATA) && q.wr;
    assign wr_ready   = (q.st == ST_DATA) && q.wr;
    assign rd_valid   = (q.st == ST_DATA) && !q.wr;
    assign rd_data    = mem_dq_in;
    assign done       = q.done;
    assign done_count = q.done ? q.moved : '0;

endmodule

// File: rtl/sbm_burst_ctrl_chk.sv
module sbm_burst_ctrl_chk #(
    parameter int ADDR_W   = 22,
    parameter int ROW_BITS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ce_n,
    input logic              mem_adv_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_clk_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic [ROW_BITS:0] done_count
);
    localparam int ROW_WORDS = 1 << ROW_BITS;

    p_adv_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |=> mem_adv_n);

    p_adv_with_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> !mem_ce_n);

    p_oe_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && mem_adv_n));

    p_done_ce_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_ce_n);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_no_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> !mem_clk_en);

    p_stall_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_clk_en) |=> $stable(mem_addr));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(done_count) <= ROW_WORDS));

endmodule

bind sbm_burst_ctrl sbm_burst_ctrl_chk #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ce_n   (mem_ce_n),
    .mem_adv_n  (mem_adv_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_clk_en (mem_clk_en),
    .mem_addr   (mem_addr),
    .done       (done),
    .done_count (done_count)
);

// File: tb/tb_sbm_burst_ctrl.sv
module tb_sbm_burst_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_len_code = '0;
    logic [3:0] cfg_latency = '0;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0, req_cont = 1'b0, abort = 1'b0;
    logic wr_valid = 1'b0, wr_ready;
    logic [DW-1:0] wr_data = '0;
    logic rd_valid, rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic done;
    logic [7:0] done_count;
    logic mem_clk_en, mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;

    // Memory model: read data is a fixed pattern of the address presented.
    assign mem_dq_in = mem_addr[15:0] ^ 16'h5A3C;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbm_burst_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_len_code(cfg_len_code), .cfg_latency(cfg_latency),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_cont(req_cont), .abort(abort),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .done_count(done_count), .mem_clk_en(mem_clk_en),
        .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    typedef struct packed {
        logic [21:0] addr;
        logic        wr;
        logic        cont;
        logic [1:0]  code;
        logic [3:0]  lat;
        logic [3:0]  stall;
        logic [7:0]  abort_at;
        logic [7:0]  words;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{22'h000100, 1'b0, 1'b0, 2'd0, 4'd3, 4'h0, 8'hFF, 8'd4},   // R4 read 4
        '{22'h000208, 1'b1, 1'b0, 2'd1, 4'd0, 4'h0, 8'hFF, 8'd8},   // R4 write 8, zero latency
        '{22'h00307C, 1'b0, 1'b0, 2'd2, 4'd5, 4'h5, 8'hFF, 8'd16},  // R4 crosses row, stalls
        '{22'h004010, 1'b1, 1'b0, 2'd3, 4'd2, 4'h2, 8'hFF, 8'd32},  // R4 write 32, stalls
        '{22'h005078, 1'b0, 1'b1, 2'd0, 4'd4, 4'h0, 8'hFF, 8'd8},   // R5 continuous to row end
        '{22'h006000, 1'b1, 1'b1, 2'd2, 4'd1, 4'h1, 8'hFF, 8'd128}, // R5 full row write
        '{22'h00707F, 1'b0, 1'b1, 2'd3, 4'd2, 4'h0, 8'hFF, 8'd1},   // R5 one word
        '{22'h008040, 1'b0, 1'b1, 2'd1, 4'd3, 4'h0, 8'd5,  8'd6},   // R7 abort
        '{22'h009000, 1'b1, 1'b0, 2'd1, 4'd1, 4'h0, 8'd2,  8'd8},   // R8 abort ignored
        '{22'h00A011, 1'b1, 1'b1, 2'd0, 4'd0, 4'h0, 8'd0,  8'd1}    // R7 abort first word
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] wpat(input int k);
        return 16'hC300 ^ k[15:0];
    endfunction

    task automatic run_vec(input vec_t v, input bit cfg_change);
        int  k = 0;
        int  last_c = -1;
        int  c = 1;
        bit  fin = 1'b0;
        bit  first = 1'b1;
        logic [AW-1:0] exp_a;
        @(negedge clk);
        req_addr = v.addr; req_write = v.wr; req_cont = v.cont;
        cfg_len_code = v.code; cfg_latency = v.lat; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (cfg_change) begin
            cfg_len_code = ~v.code;
            cfg_latency = v.lat + 4'd3;
        end
        #1;
        chk(mem_ce_n == 1'b0 && mem_adv_n == 1'b0, "R2", "ce/adv low in address cycle",
            {mem_ce_n, mem_adv_n}, 0);
        chk(mem_addr == v.addr, "R2", "address at latch", mem_addr, v.addr);
        chk(mem_we_n == !v.wr, "R2", "direction at latch", mem_we_n, !v.wr);
        chk(mem_clk_en == 1'b1, "R3", "clock enable in address cycle", mem_clk_en, 1);
        while (!fin) begin
            @(negedge clk);
            abort = 1'b0;
            rd_ready = !v.stall[c % 4];
            wr_valid = !v.stall[c % 4];
            wr_data  = wpat(k);
            #1;
            if (done) begin
                fin = 1'b1;
                chk(mem_ce_n == 1'b1, "R6", "ce high at done", mem_ce_n, 1);
                chk(c == last_c + 1, "R6", "done one cycle after last word", c, last_c + 1);
                chk(done_count == v.words, "R6", "done count", done_count, v.words);
                chk(k == v.words, "R4", "words seen by host", k, v.words);
            end else if (rd_valid || wr_ready) begin
                if (first) begin
                    chk(c == v.lat + 1, "R3", "first data cycle", c, v.lat + 1);
                    first = 1'b0;
                end
                chk(mem_adv_n == 1'b1 && mem_ce_n == 1'b0, "R2", "adv high, ce low in data",
                    {mem_ce_n, mem_adv_n}, 1);
                exp_a = v.addr + AW'(k);
                chk(mem_addr == exp_a, v.cont ? "R5" : "R4", "data address", mem_addr, exp_a);
                if (v.wr) begin
                    chk(mem_dq_oe && mem_oe_n, "R10", "write drive, oe high",
                        {mem_dq_oe, mem_oe_n}, 2'b11);
                    chk(mem_clk_en == wr_valid, "R10", "clk_en follows wr_valid",
                        mem_clk_en, wr_valid);
                    if (wr_valid)
                        chk(mem_dq_out == wpat(k), "R10", "write word", mem_dq_out, wpat(k));
                end else begin
                    chk(mem_oe_n == 1'b0, "R9", "oe low in read data", mem_oe_n, 0);
                    chk(mem_clk_en == rd_ready, "R9", "clk_en follows rd_ready",
                        mem_clk_en, rd_ready);
                    if (rd_ready)
                        chk(rd_data == (exp_a[15:0] ^ 16'h5A3C), "R9", "read word",
                            rd_data, exp_a[15:0] ^ 16'h5A3C);
                end
                if (v.wr ? wr_valid : rd_ready) begin
                    if (k == int'(v.abort_at)) abort = 1'b1;
                    k++;
                    last_c = c;
                end
            end else begin
                chk(mem_clk_en && mem_oe_n && mem_adv_n && !mem_ce_n, "R3",
                    "latency cycle pins", {mem_clk_en, mem_oe_n, mem_adv_n, mem_ce_n}, 4'b1110);
            end
            c++;
            if (c > 600) begin
                chk(1'b0, "R6", "burst never ended", c, 0);
                fin = 1'b1;
            end
        end
        @(negedge clk);
        abort = 1'b0;
        #1;
        chk(done == 1'b0 && req_ready == 1'b1, "R6", "done one cycle, idle after",
            {done, req_ready}, 1);
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc_total);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        #1;
        // R1 state held in reset
        chk(mem_ce_n && mem_adv_n && mem_we_n && mem_oe_n, "R1", "memory pins in reset",
            {mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n}, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(mem_ce_n && mem_adv_n && mem_we_n && mem_oe_n, "R1", "idle memory pins",
            {mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n}, 4'hF);
        chk(!mem_clk_en && !done && done_count == 0 && req_ready, "R1", "idle host side",
            {mem_clk_en, done, done_count, req_ready}, 1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R11 configuration changed right after acceptance must not matter
        run_vec(VECS[0], 1'b1);
        run_vec(VECS[3], 1'b1);

        // R1 back to idle after all bursts
        @(negedge clk);
        #1;
        chk(mem_ce_n && !mem_clk_en && mem_oe_n, "R1", "idle after bursts",
            {mem_ce_n, mem_clk_en, mem_oe_n}, 3'b101);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule